// File: doc/BRIEF.md
# Secure-Area Bank Fetch Sequencer

This block is the host-side controller that pulls the four protected banks at the bottom of a cartridge image out of the card. These are banks 4 to 7, which cover byte addresses 0x4000 to 0x7FFF, at 4 KB each. On a start request it checks the 32-bit card identifier. The top bit of that identifier tells a quick card from a slow card, and the sequencer then picks one of two command schemes.

A quick card is sent one command per bank, and that command returns the whole bank. A slow card needs more steps for each bank. The host first sends a commit command that reads nothing back. It then holds off for the 16-bit timeout value taken from the cartridge header. After that it sends the same command eight times with no pause between them, and each of these returns 512 bytes.

The sequencer drives a command strobe together with the bank number and the number of bytes the card is expected to return for that command. Incoming bytes are passed on to the output tagged with their bank and their offset inside that bank. A one-cycle completion pulse marks the end of all four banks. The fetch order is programmable. Encryption and the physical card bus are handled elsewhere.

Top module: `sfs_fetch_seq`

## Requirements
- R1: When start is accepted with card_id bit 31 equal to 0, the block issues exactly 4 commands, and each one has cmd_len equal to the full bank size (4096 by default).
- R2: When card_id bit 31 is 1, each bank gets one command with cmd_len 0, followed by 8 commands for the same bank with cmd_len equal to the chunk size (512 by default). A full fetch is 36 commands.
- R3: After a command with cmd_len 0, the next cmd_strobe comes exactly hdr_timeout+2 cycles later. The hdr_timeout value is latched when start is accepted.
- R4: After any command with a nonzero cmd_len, the next cmd_strobe comes in the cycle right after the last byte of that transfer is accepted. In the quick scheme, hdr_timeout has no effect on timing.
- R5: For the i-th bank fetched (i = 0..3), cmd_bank equals 4 plus the 2-bit entry fetch_order[2i+1:2i]. Banks are fetched in entry order.
- R6: A byte is accepted when rx_valid is high while a transfer is open. In that same cycle, out_valid is high, and out_data, out_bank and out_offset carry the byte, its bank and its offset within the bank. The offset starts at 0 for each bank and keeps counting across the repeated slow reads.
- R7: done is high for exactly one cycle, in the cycle after the last byte of the fourth bank is accepted. busy is low from then on.
- R8: A start with card_id equal to all zeros or all ones sets id_error and issues no command, and busy stays low. id_error clears on the next start with a valid card_id.
- R9: rx_valid has no effect while no transfer is open, which covers idle and the post-commit wait. out_valid stays low in those cycles and the bank offsets are not disturbed.
- R10: A start while busy is ignored. The running fetch, its command count and id_error are unchanged.
- R11: After reset, cmd_strobe, out_valid, busy, done and id_error are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a fetch; only acted on while idle |
| card_id | input | 32 | Card identifier; bit 31 selects the slow scheme |
| hdr_timeout | input | 16 | Post-commit wait in cycles, taken from the header |
| fetch_order | input | 8 | Four 2-bit bank entries; entry i selects bank 4+entry |
| cmd_strobe | output | 1 | One-cycle command issue |
| cmd_bank | output | 16 | Bank number of the current command |
| cmd_len | output | 13 | Bytes expected back for the current command |
| rx_valid | input | 1 | Card byte present |
| rx_data | input | 8 | Card byte |
| out_valid | output | 1 | Accepted byte present on the output |
| out_data | output | 8 | Accepted byte |
| out_bank | output | 16 | Bank of the accepted byte |
| out_offset | output | 12 | Offset of the accepted byte in its bank |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle pulse after the last byte |
| id_error | output | 1 | Last start carried an all-zeros or all-ones identifier |

## Verification
The bench builds the sequencer with BANK_BYTES=256 and SLOW_CHUNK=32. This keeps the ratio of eight repeated reads per bank and the full 36-command slow sequence, while a whole four-bank fetch fits in about a thousand bytes. That makes it possible to run several fetches back to back. The runs cover both schemes, header timeouts of 0, 1, 5, 40 and 100, reversed and duplicated bank orders, and cards that stall every other byte. Spurious rx_valid is driven both while idle and during the post-commit wait.

// File: rtl/sfs_pkg.sv
// Package: shared state encoding for the secure-area fetch sequencer.
// Assumes: included first in compile order.
package sfs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RECV  = 2'd2,
        ST_WAIT  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/sfs_id_check.sv
// Module: classifies a card identifier.
// It flags identifiers that are all zeros or all ones as unusable and
// reports the speed bit (top bit, 1 = slow card).
// Assumes: purely combinational; the caller latches the results.
module sfs_id_check #(
    parameter int ID_W = 32
) (
    input  logic [ID_W-1:0] id_in,
    output logic            id_bad,
    output logic            id_slow
);

    // Decode the two unusable patterns and the speed bit.
    always_comb begin
        id_bad  = (id_in == '0) || (id_in == '1);
        id_slow = id_in[ID_W-1];
    end

endmodule

// File: rtl/sfs_wait_timer.sv
// Module: down-counter for the post-commit hold-off.
// Loading sets the count; it then counts down to zero and rests there.
// Assumes: load and counting never overlap within one cycle.
module sfs_wait_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TO_W-1:0] load_val,
    output logic            expired
);

    logic [TO_W-1:0] cnt;

    // Load or decrement the hold-off count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Signal that the hold-off has run out.
    always_comb expired = (cnt == '0);

    // R3: without a load the count may never rise
    assert_timer_no_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/sfs_byte_track.sv
// Module: byte counters for one transfer and for the running bank offset.
// Provides the in-bank offset of the next byte and flags the last byte
// of the open transfer.
// Assumes: xfer_len is nonzero whenever accept is raised.
module sfs_byte_track #(
    parameter int LEN_W = 13,
    parameter int OFS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_xfer,
    input  logic             clr_bank,
    input  logic             accept,
    input  logic [LEN_W-1:0] xfer_len,
    output logic [OFS_W-1:0] ofs,
    output logic             last_byte
);

    logic [LEN_W-1:0] xfer_cnt;

    // Count bytes inside the current transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_cnt <= '0;
        end else if (clr_xfer) begin
            xfer_cnt <= '0;
        end else if (accept) begin
            xfer_cnt <= xfer_cnt + 1'b1;
        end
    end

    // Count bytes inside the current bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs <= '0;
        end else if (clr_bank) begin
            ofs <= '0;
        end else if (accept) begin
            ofs <= ofs + 1'b1;
        end
    end

    // Mark the byte that closes the transfer.
    always_comb last_byte = (xfer_cnt == xfer_len - LEN_W'(1));

    // R6: no byte is taken beyond the announced length
    assert_xfer_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (xfer_cnt < xfer_len));

endmodule

// File: rtl/sfs_fetch_seq.sv
// Module: secure-area bank fetch sequencer (top).
// It reads the card identifier on start and runs either the single-read
// scheme (one full-bank command per bank) or the slow scheme (a commit
// with no data, a header-timed wait, then repeated chunk reads). It then
// forwards the received bytes tagged with bank and offset.
// Assumes: the card returns exactly cmd_len bytes after each strobe and
// the inputs card_id, hdr_timeout and fetch_order are valid at start.
module sfs_fetch_seq
    import sfs_pkg::*;
#(
    parameter int BANK_BYTES = 4096,
    parameter int SLOW_CHUNK = 512,
    parameter int NUM_BANKS  = 4,
    parameter int FIRST_BANK = 4,
    parameter int ID_W       = 32,
    parameter int TO_W       = 16,
    parameter int BANK_W     = 16,
    localparam int REPS      = BANK_BYTES / SLOW_CHUNK,
    localparam int REP_W     = (REPS > 1) ? $clog2(REPS) : 1,
    localparam int ORD_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int LEN_W     = $clog2(BANK_BYTES) + 1,
    localparam int OFS_W     = $clog2(BANK_BYTES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [ID_W-1:0]            card_id,
    input  logic [TO_W-1:0]            hdr_timeout,
    input  logic [NUM_BANKS*ORD_W-1:0] fetch_order,
    output logic                       cmd_strobe,
    output logic [BANK_W-1:0]          cmd_bank,
    output logic [LEN_W-1:0]           cmd_len,
    input  logic                       rx_valid,
    input  logic [7:0]                 rx_data,
    output logic                       out_valid,
    output logic [7:0]                 out_data,
    output logic [BANK_W-1:0]          out_bank,
    output logic [OFS_W-1:0]           out_offset,
    output logic                       busy,
    output logic                       done,
    output logic                       id_error
);

    seq_state_e                 state;
    logic                       slow_q;
    logic                       committed_q;
    logic [TO_W-1:0]            timeout_q;
    logic [NUM_BANKS*ORD_W-1:0] order_q;
    logic [ORD_W-1:0]           bank_idx;
    logic [REP_W-1:0]           rep_q;
    logic [LEN_W-1:0]           cur_len;
    logic                       done_q;
    logic                       err_q;

    logic                       id_bad;
    logic                       id_slow;
    logic                       tmr_expired;
    logic                       tmr_load;
    logic                       accept;
    logic                       last_byte;
    logic [OFS_W-1:0]           ofs;
    logic [ORD_W-1:0]           order_entry;

    sfs_id_check #(.ID_W(ID_W)) u_id_check (
        .id_in   (card_id),
        .id_bad  (id_bad),
        .id_slow (id_slow)
    );

    sfs_wait_timer #(.TO_W(TO_W)) u_wait_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (timeout_q),
        .expired  (tmr_expired)
    );

    sfs_byte_track #(.LEN_W(LEN_W), .OFS_W(OFS_W)) u_byte_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_xfer  (state == ST_ISSUE),
        .clr_bank  ((state == ST_ISSUE) && (!slow_q || !committed_q)),
        .accept    (accept),
        .xfer_len  (cur_len),
        .ofs       (ofs),
        .last_byte (last_byte)
    );

    // Pick the order entry of the bank in progress.
    always_comb order_entry = order_q[bank_idx*ORD_W +: ORD_W];

    // Form the command fields and the output stream.
    always_comb begin
        cmd_strobe = (state == ST_ISSUE);
        cmd_bank   = BANK_W'(FIRST_BANK) + BANK_W'(order_entry);
        if (!slow_q) begin
            cmd_len = LEN_W'(BANK_BYTES);
        end else if (!committed_q) begin
            cmd_len = '0;
        end else begin
            cmd_len = LEN_W'(SLOW_CHUNK);
        end
        tmr_load   = cmd_strobe && (cmd_len == '0);
        accept     = (state == ST_RECV) && rx_valid;
        out_valid  = accept;
        out_data   = rx_data;
        out_bank   = cmd_bank;
        out_offset = ofs;
        busy       = (state != ST_IDLE);
        done       = done_q;
        id_error   = err_q;
    end

    // Sequence commands, waits and bank switches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            slow_q      <= 1'b0;
            committed_q <= 1'b0;
            timeout_q   <= '0;
            order_q     <= '0;
            bank_idx    <= '0;
            rep_q       <= '0;
            cur_len     <= '0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        err_q <= id_bad;
                        if (!id_bad) begin
                            slow_q      <= id_slow;
                            timeout_q   <= hdr_timeout;
                            order_q     <= fetch_order;
                            bank_idx    <= '0;
                            rep_q       <= '0;
                            committed_q <= 1'b0;
                            state       <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    cur_len <= cmd_len;
                    state   <= (cmd_len == '0) ? ST_WAIT : ST_RECV;
                end
                ST_WAIT: begin
                    if (tmr_expired) begin
                        committed_q <= 1'b1;
                        state       <= ST_ISSUE;
                    end
                end
                ST_RECV: begin
                    if (accept && last_byte) begin
                        if (slow_q && (rep_q != REP_W'(REPS - 1))) begin
                            rep_q <= rep_q + 1'b1;
                            state <= ST_ISSUE;
                        end else begin
                            rep_q       <= '0;
                            committed_q <= 1'b0;
                            if (bank_idx == ORD_W'(NUM_BANKS - 1)) begin
                                done_q <= 1'b1;
                                state  <= ST_IDLE;
                            end else begin
                                bank_idx <= bank_idx + 1'b1;
                                state    <= ST_ISSUE;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: a quick card is always asked for a whole bank
    assert_fast_full_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && !slow_q) |-> (cmd_len == LEN_W'(BANK_BYTES)));

    // R2: every strobe is a single cycle
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |=> !cmd_strobe);

    // R3: a commit is never followed directly by data or another command
    assert_commit_then_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && (cmd_len == '0)) |=> (!cmd_strobe && !out_valid));

    // R5: command banks stay inside the protected range
    assert_bank_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> ((cmd_bank >= BANK_W'(FIRST_BANK)) &&
                        (cmd_bank <  BANK_W'(FIRST_BANK + NUM_BANKS))));

    // R7: completion leaves the block idle
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: a rejected identifier never starts a fetch
    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        id_error |-> !busy);

endmodule

// File: tb/test_sfs_fetch_seq.sv
module test_sfs_fetch_seq;

    localparam int BANK  = 256;
    localparam int CHUNK = 32;
    localparam int REPS  = BANK / CHUNK;
    localparam int NB    = 4;
    localparam int LEN_W = $clog2(BANK) + 1;
    localparam int OFS_W = $clog2(BANK);

    // id[57:26] timeout[25:10] order[9:2] gappy[1] noisy[0]
    localparam logic [57:0] VEC [0:5] = '{
        {32'h0000_0FC2, 16'd100, 8'b11_10_01_00, 1'b0, 1'b0},
        {32'h8000_0F80, 16'd5,   8'b00_01_10_11, 1'b0, 1'b1},
        {32'h8000_1FAE, 16'd0,   8'b10_00_11_01, 1'b1, 1'b0},
        {32'h4000_3FC2, 16'd0,   8'b01_11_00_10, 1'b1, 1'b0},
        {32'hE001_07C2, 16'd40,  8'b00_00_11_11, 1'b0, 1'b1},
        {32'hFFFF_FFFE, 16'd1,   8'b11_10_01_00, 1'b0, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [31:0]       card_id = '0;
    logic [15:0]       hdr_timeout = '0;
    logic [7:0]        fetch_order = '0;
    logic              cmd_strobe;
    logic [15:0]       cmd_bank;
    logic [LEN_W-1:0]  cmd_len;
    logic              rx_valid;
    logic [7:0]        rx_data;
    logic              out_valid;
    logic [7:0]        out_data;
    logic [15:0]       out_bank;
    logic [OFS_W-1:0]  out_offset;
    logic              busy, done, id_error;

    logic        card_rv = 1'b0;
    logic [7:0]  card_rd = '0;
    logic        idle_noise = 1'b0;
    assign rx_valid = card_rv | idle_noise;
    assign rx_data  = card_rv ? card_rd : 8'h55;

    int tests = 0, fails = 0, cyc = 0;
    bit summary_done = 1'b0;

    // per-run expectations
    bit  mon_on = 1'b0, run_slow = 1'b0, run_gappy = 1'b0, run_noisy = 1'b0;
    int  run_to = 0, n_cmd = 0, prev_cyc = 0, prev_len = 0, byte_n = 0;
    int  last_cyc = -10, done_n = 0;
    logic [7:0] run_order = '0;

    sfs_fetch_seq #(.BANK_BYTES(BANK), .SLOW_CHUNK(CHUNK)) i_sfs_fetch_seq (
        .clk, .rst_n, .start, .card_id, .hdr_timeout, .fetch_order,
        .cmd_strobe, .cmd_bank, .cmd_len, .rx_valid, .rx_data,
        .out_valid, .out_data, .out_bank, .out_offset, .busy, .done, .id_error
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] pattern(input int bank, input int ptr);
        return 8'((bank * 37 + ptr) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary;
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
        end
    endtask

    // Card model: streams cmd_len bytes after each strobe, optional stalls and noise.
    initial begin
        int rem = 0, ptr = 0, cbank = 0, noise = 0;
        bit tog = 1'b0;
        forever begin
            @(posedge clk); #1;
            if (rem > 0 && !(run_gappy && tog)) begin
                card_rv = 1'b1; card_rd = pattern(cbank, ptr); ptr++; rem--;
            end else if (noise > 0) begin
                card_rv = 1'b1; card_rd = 8'hEE; noise--;
            end else begin
                card_rv = 1'b0;
            end
            tog = !tog;
            if (cmd_strobe) begin
                cbank = int'(cmd_bank);
                if (cmd_len == 0 || cmd_len == LEN_W'(BANK)) ptr = 0;
                rem = int'(cmd_len);
                if (cmd_len == 0 && run_noisy) noise = int'(hdr_timeout);
                tog = 1'b0;
            end
        end
    end

    // Monitor: checks commands, byte stream and completion at the negative edge.
    always @(negedge clk) begin
        if (mon_on) begin
            if (cmd_strobe) begin
                int idx, elen;
                elen = run_slow ? ((n_cmd % (REPS + 1)) == 0 ? 0 : CHUNK) : BANK;
                idx  = run_slow ? n_cmd / (REPS + 1) : n_cmd;
                chk(int'(cmd_len) == elen, run_slow ? "R2 len" : "R1 len", int'(cmd_len), elen);
                if (idx < NB)
                    chk(int'(cmd_bank) == 4 + int'((run_order >> (2 * idx)) & 3),
                        "R5 bank", int'(cmd_bank), 4 + int'((run_order >> (2 * idx)) & 3));
                if (n_cmd > 0 && !run_gappy) begin
                    int egap;
                    egap = (prev_len == 0) ? run_to + 2 : prev_len + 1;
                    chk(cyc - prev_cyc == egap, prev_len == 0 ? "R3 gap" : "R4 gap",
                        cyc - prev_cyc, egap);
                end
                prev_cyc = cyc; prev_len = int'(cmd_len); n_cmd++;
            end
            if (out_valid) begin
                int bi, eofs, ebank;
                bi    = byte_n / BANK;
                eofs  = byte_n % BANK;
                ebank = 4 + int'((run_order >> (2 * (bi % NB))) & 3);
                chk(int'(out_offset) == eofs, "R6 offset", int'(out_offset), eofs);
                chk(int'(out_bank) == ebank, "R6 bank", int'(out_bank), ebank);
                chk(out_data == pattern(ebank, eofs), "R6 data R9",
                    int'(out_data), int'(pattern(ebank, eofs)));
                byte_n++;
                if (byte_n == NB * BANK) last_cyc = cyc;
            end
            if (done) begin
                done_n++;
                chk(last_cyc == cyc - 1, "R7 done timing", cyc - last_cyc, 1);
            end
        end
    end

    task automatic run_vec(input logic [57:0] v);
        int w;
        card_id     = v[57:26];
        hdr_timeout = v[25:10];
        fetch_order = v[9:2];
        run_gappy   = v[1];
        run_noisy   = v[0];
        run_slow    = v[57];
        run_to      = int'(v[25:10]);
        run_order   = v[9:2];
        n_cmd = 0; byte_n = 0; done_n = 0; last_cyc = -10; prev_len = 0;
        mon_on = 1'b1;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        // R10: a start with a bad identifier in mid-run is ignored
        repeat (20) @(posedge clk);
        #1 card_id = 32'h0; start = 1'b1;
        @(posedge clk); #1 start = 1'b0; card_id = v[57:26];
        w = 0;
        while (done_n == 0 && w < 20000) begin @(negedge clk); w++; end
        chk(done_n == 1, "R7 done seen", done_n, 1);
        repeat (3) @(negedge clk);
        chk(n_cmd == (run_slow ? NB * (REPS + 1) : NB), run_slow ? "R2 count" : "R1 count",
            n_cmd, run_slow ? NB * (REPS + 1) : NB);
        chk(byte_n == NB * BANK, "R6 bytes R9", byte_n, NB * BANK);
        chk(done_n == 1, "R7 single pulse", done_n, 1);
        chk(busy == 1'b0, "R7 idle after", int'(busy), 0);
        chk(id_error == 1'b0, "R10 err unchanged", int'(id_error), 0);
        mon_on = 1'b0;
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        summary;
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(cmd_strobe == 0 && out_valid == 0 && busy == 0 && done == 0 && id_error == 0,
            "R11 reset", int'({cmd_strobe, out_valid, busy, done, id_error}), 0);

        // R9: rx_valid while idle is ignored
        @(posedge clk); #1 idle_noise = 1'b1;
        repeat (2) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R9 idle rx", int'(out_valid), 0);
        end
        @(posedge clk); #1 idle_noise = 1'b0;

        foreach (VEC[i]) run_vec(VEC[i]);

        // R8: all-zeros and all-ones identifiers
        for (int k = 0; k < 2; k++) begin
            @(posedge clk); #1 card_id = (k == 0) ? 32'h0 : 32'hFFFF_FFFF; start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                chk(cmd_strobe == 1'b0 && busy == 1'b0, "R8 no command",
                    int'({cmd_strobe, busy}), 0);
            end
            chk(id_error == 1'b1, "R8 error flag", int'(id_error), 1);
        end
        // R8: a valid start clears the flag
        @(posedge clk); #1 card_id = 32'h0000_0FC2; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        chk(id_error == 1'b0 && busy == 1'b1, "R8 error cleared",
            int'({id_error, busy}), 1);
        while (busy) @(negedge clk);

        summary;
        $finish;
    end

endmodule